// File: doc/BRIEF.md
# Phase-Count Threshold Scaler

When phases of a current-sharing group are dropped, the output ripple gets larger. A fast transient detector that keeps the threshold it was given for the full group would then trip on ripple alone. This block prevents that by raising the detector's inner threshold in proportion. It takes three values: the threshold set for the complete group, the number of members in the group, and the number of members that are active (neither faulted nor switched off on purpose). The two counts come straight from the group configuration. The block multiplies the threshold by the member count, divides by the active count, and rounds the result up to the next step of the threshold grid.

Threshold codes count steps of 0.5 % of the configured output voltage. A one-cycle change strobe starts a new calculation, which runs in a sequential restoring divider. When the divider finishes, the block loads the new code and pulses a done flag. If the active count is zero, the block keeps the code it already has and raises an error flag. A group has at most eight members, so the default 4-bit counts have room to spare.

Top module: `ripple_thresh_scaler`

## Requirements
- R1: After reset, the threshold code is 0, and done, busy and the zero-active error flag are all low.
- R2: Codes count 0.5 %-of-Vout steps. A completed calculation yields ceil(full_code × total / active).
- R3: A fractional quotient is always rounded up to the next step and never down. An exact quotient is not incremented.
- R4: A result larger than 2^THR_W − 1 saturates to 2^THR_W − 1 (255 by default).
- R5: If start is accepted while the block is idle with a nonzero active count, busy rises on the next cycle. Exactly THR_W+CNT_W cycles after the accepting edge (12 by default), done pulses for one cycle and the new code appears in that same cycle. The code changes only in a cycle where done is high.
- R6: If start is accepted with an active count of zero, done and the error flag both rise on the next cycle and the code stays unchanged. The error flag stays high until a later calculation completes, and that completion clears it.
- R7: While busy is high, start is ignored. The result belongs to the operands captured at the accepting edge.
- R8: When the active count equals the total, the new code equals the full-group code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Change strobe. Captures the operands when idle |
| thr_full | input | THR_W | Full-group threshold, in 0.5 % steps |
| n_total | input | CNT_W | Total members of the group |
| n_active | input | CNT_W | Active members (not faulted, not deactivated) |
| thr_scaled | output | THR_W | Scaled threshold code, in 0.5 % steps |
| done | output | 1 | One-cycle pulse when a calculation ends or a zero-active request is rejected |
| busy | output | 1 | Divider running |
| err_zero | output | 1 | Last request had zero active members |

## Verification
The properties assume start is a synchronous strobe. They do not depend on any particular relation between the counts. The result is correct even when the active count is larger than the total, so the stimulus may stay inside the physically meaningful range of 1 to 8 without that limit being required. The stimulus drives operands and start on the falling edge. It holds the operands steady until the strobe has been sampled. It includes deliberate extra strobes, with different operands, while the divider is running, to show that the captured values win.

// File: rtl/ripple_thresh_scaler.sv
module ripple_thresh_scaler #(
  parameter int THR_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [THR_W-1:0] thr_full,
  input  logic [CNT_W-1:0] n_total,
  input  logic [CNT_W-1:0] n_active,
  output logic [THR_W-1:0] thr_scaled,
  output logic             done,
  output logic             busy,
  output logic             err_zero
);
  localparam int NUM_W  = THR_W + CNT_W;
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  quo;
  logic [CNT_W:0]    rem;
  logic [CNT_W-1:0]  div;
  logic [STEP_W-1:0] step;

  wire [CNT_W:0]   trial   = {rem[CNT_W-1:0], quo[NUM_W-1]};
  wire             take    = trial >= {1'b0, div};
  wire [CNT_W:0]   rem_nxt = take ? trial - {1'b0, div} : trial;
  wire [NUM_W-1:0] quo_nxt = {quo[NUM_W-2:0], take};
  wire [NUM_W-1:0] numer   = NUM_W'(thr_full) * NUM_W'(n_total)
                           + NUM_W'(n_active) - NUM_W'(1);
  wire             ovf     = |quo_nxt[NUM_W-1:THR_W];
  wire [THR_W-1:0] result  = ovf ? {THR_W{1'b1}} : quo_nxt[THR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo        <= '0;
      rem        <= '0;
      div        <= '0;
      step       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err_zero   <= 1'b0;
      thr_scaled <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        quo <= quo_nxt;
        rem <= rem_nxt;
        if (step == '0) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          err_zero   <= 1'b0;
          thr_scaled <= result;
        end else begin
          step <= step - 1'b1;
        end
      end else if (start) begin
        if (n_active == '0) begin
          err_zero <= 1'b1;
          done     <= 1'b1;
        end else begin
          quo  <= numer;
          rem  <= '0;
          div  <= n_active;
          step <= STEP_W'(NUM_W - 1);
          busy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ripple_thresh_scaler_chk.sv
module ripple_thresh_scaler_chk #(
  parameter int THR_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] n_active,
  input logic [THR_W-1:0] thr_scaled,
  input logic             done,
  input logic             busy,
  input logic             err_zero
);
  p_code_moves_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr_scaled) |-> done);
  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_ends_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  p_accept_goes_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_active != '0) |=> (busy && !done));
  p_zero_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_active == '0) |=> (err_zero && done && !busy));
  p_zero_holds_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_zero) |-> $stable(thr_scaled));
  p_success_clears_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !err_zero);
endmodule

bind ripple_thresh_scaler ripple_thresh_scaler_chk #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .n_active(n_active),
  .thr_scaled(thr_scaled), .done(done), .busy(busy), .err_zero(err_zero)
);

// File: tb/tb_ripple_thresh_scaler.sv
module tb_ripple_thresh_scaler;
  localparam int THR_W = 8;
  localparam int CNT_W = 4;
  localparam int LAT   = THR_W + CNT_W;
  localparam int MAXC  = (1 << THR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [THR_W-1:0] thr_full = '0;
  logic [CNT_W-1:0] n_total = '0;
  logic [CNT_W-1:0] n_active = '0;
  logic [THR_W-1:0] thr_scaled;
  logic done, busy, err_zero;

  always #4 clk = ~clk;

  ripple_thresh_scaler #(.THR_W(THR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .thr_full(thr_full),
    .n_total(n_total), .n_active(n_active), .thr_scaled(thr_scaled),
    .done(done), .busy(busy), .err_zero(err_zero)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  int m_thr = 0, m_res = 0, m_cnt = 0;
  bit m_done = 0, m_busy = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr <= 0; m_done <= 0; m_busy <= 0; m_err <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_err <= 0; m_thr <= m_res;
        end else m_cnt <= m_cnt - 1;
      end else if (start) begin
        if (n_active == 0) begin
          m_err <= 1; m_done <= 1;
        end else begin
          int q;
          q = (int'(thr_full) * int'(n_total) + int'(n_active) - 1) / int'(n_active);
          m_res <= (q > MAXC) ? MAXC : q;
          m_busy <= 1; m_cnt <= LAT;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(thr_scaled) != m_thr || done != m_done || busy != m_busy || err_zero != m_err) begin
      errors++;
      $display("FAIL %s: thr=%0d done=%0b busy=%0b err=%0b expected thr=%0d done=%0b busy=%0b err=%0b",
               tag, thr_scaled, done, busy, err_zero, m_thr, m_done, m_busy, m_err);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic op(input int f, input int t, input int a, input string r, input bit poke);
    @(negedge clk);
    tag = r; thr_full = THR_W'(f); n_total = CNT_W'(t); n_active = CNT_W'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      thr_full = 8'd99; n_total = 4'd8; n_active = 4'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; n_active = 4'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic expect_code(input int exp, input string r);
    checks++;
    if (int'(thr_scaled) != exp) begin
      errors++;
      $display("FAIL %s: thr=%0d expected %0d", r, thr_scaled, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_code(0, "R1");
    rst_n = 1'b1;
    op(20, 3, 3, "R8", 0);  expect_code(20, "R8");
    op(10, 3, 2, "R2", 0);  expect_code(15, "R2");
    op(10, 4, 3, "R3", 0);  expect_code(14, "R3");
    op(7, 8, 5, "R3", 0);   expect_code(12, "R3");
    op(0, 8, 3, "R2", 0);   expect_code(0, "R2");
    op(200, 8, 1, "R4", 0); expect_code(MAXC, "R4");
    op(255, 1, 1, "R4", 0); expect_code(255, "R4");
    op(9, 8, 7, "R5", 0);   expect_code(11, "R5");
    op(33, 6, 0, "R6", 0);  expect_code(11, "R6");
    op(30, 8, 6, "R6", 0);  expect_code(40, "R6");
    op(12, 5, 4, "R7", 1);  expect_code(15, "R7");
    op(1, 8, 8, "R8", 0);   expect_code(1, "R8");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule